// File: doc/BRIEF.md
# Mode-Switched Parallel Port Host Front End

This block is the host-facing register layer of an extended-capability parallel port. A three-bit mode field, held in an extended control register, decides what each host address offset reaches. Depending on the mode, an offset maps to the plain output latch, a tagged transmit queue, the status and control registers, a test loopback queue, or the configuration registers.

The host side is a legacy bus. It carries an address offset, an address-enable line that blocks all decoding while high, active-low read and write strobes, and an 8-bit data path. Strobes are sampled in the block clock domain. A write takes effect on the rising edge of its strobe. A read returns data combinationally while its strobe is low, and it pops the test queue on the rising edge of the strobe.

Queue entries leave through a valid/ready stream that a transmit engine consumes. Each entry is a tag bit plus a byte. The tag records whether the byte was written as a command (address/RLE) or as plain data.

Top module: `ppf_host_front`

## Requirements
- R1: After reset the mode field is 000, the direction bit (control bit 5) is 0, the output latch and control register are 0x00, the queue is empty and `tx_valid` is low. The extended control register (+402h) then reads 0x02. Its layout is: bits 7:5 mode, bit 2 full, bit 1 empty, bit 0 sticky overflow.
- R2: In modes 000 and 001, a write to +000h loads the byte into the latch that drives `pd_out`. A read of +000h returns the level on `pd_in`. `pd_oe` is high exactly when the direction bit is 0.
- R3: While `host_aen` is high, writes change nothing and reads return 0xFF.
- R4: In mode 011, a write to +000h enqueues the byte with tag 1, and a write to +400h enqueues it with tag 0. Entries leave in write order.
- R5: In mode 011 with the direction bit set to 1, a write to +000h is dropped.
- R6: In mode 010, a write to +400h enqueues the byte with tag 0.
- R7: The queue holds DEPTH (16) entries. A write to a full queue is dropped and sets the overflow bit of +402h. Writing +402h with bit 0 set clears the overflow bit.
- R8: An entry leaves only on a cycle with both `tx_valid` and `tx_ready` high. While `tx_valid` is high and `tx_ready` is low, `tx_tag` and `tx_data` hold steady.
- R9: In mode 110, writes to +400h enqueue the byte and `tx_valid` stays low. A read of +400h returns the head entry's byte and removes that entry when the read strobe rises.
- R10: In mode 111, +400h reads the fixed value CFGA_VAL (0x14) and ignores writes. +401h is a read/write byte.
- R11: In every mode, +001h reads `status_in` and +002h is the read/write control register driven on `ctrl_out`.
- R12: An offset not defined in the current mode reads 0xFF and ignores writes. In mode 101, only +001h, +002h and +402h respond.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 11 | Offset from the port base |
| host_aen | input | 1 | High blocks all decoding |
| host_nior | input | 1 | Active-low read strobe |
| host_niow | input | 1 | Active-low write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, 0xFF when idle |
| status_in | input | 8 | Peripheral status lines |
| ctrl_out | output | 8 | Control register contents |
| pd_out | output | 8 | Output latch toward the port pins |
| pd_in | input | 8 | Sensed port pin levels |
| pd_oe | output | 1 | Port pin drive enable |
| tx_valid | output | 1 | Queue head available to the engine |
| tx_ready | input | 1 | Engine accepts the head this cycle |
| tx_tag | output | 1 | 1 = command entry, 0 = data entry |
| tx_data | output | 8 | Head entry byte |

## Verification
The assertions assume three things about the host. It holds address, data and AEN steady from the falling edge of a strobe until one clock after the strobe rises. It never drives both strobes low together. It keeps `host_niow` high through reset. The bench's bus tasks change all host signals at the falling clock edge and keep each strobe low for one full cycle, so every access obeys these rules. The engine side may hold `tx_ready` low for any length of time; the bench does this while filling the queue and while watching the head for stability.

// File: rtl/ppf_pkg.sv
package ppf_pkg;

  typedef enum logic [2:0] {
    MODE_STD   = 3'b000,
    MODE_BIDIR = 3'b001,
    MODE_PFIFO = 3'b010,
    MODE_EXT   = 3'b011,
    MODE_EPP   = 3'b100,
    MODE_RSVD  = 3'b101,
    MODE_TEST  = 3'b110,
    MODE_CFG   = 3'b111
  } mode_e;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_LATCH,
    SEL_CMDQ,
    SEL_STAT,
    SEL_CTRL,
    SEL_DATQ,
    SEL_TSTQ,
    SEL_CFGA,
    SEL_CFGB,
    SEL_XCTL
  } sel_e;

  // control register bit that selects reverse direction
  localparam int DIR_BIT = 5;

endpackage

// File: rtl/ppf_edge.sv
module ppf_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= strobe_n;
  end

  assign rise = ~prev_q & strobe_n;
endmodule

// File: rtl/ppf_decode.sv
module ppf_decode
  import ppf_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  mode_e             mode,
  output sel_e              sel
);
  localparam logic [ADDR_W-1:0] OFS_LO0 = ADDR_W'(11'h000);
  localparam logic [ADDR_W-1:0] OFS_LO1 = ADDR_W'(11'h001);
  localparam logic [ADDR_W-1:0] OFS_LO2 = ADDR_W'(11'h002);
  localparam logic [ADDR_W-1:0] OFS_HI0 = ADDR_W'(11'h400);
  localparam logic [ADDR_W-1:0] OFS_HI1 = ADDR_W'(11'h401);
  localparam logic [ADDR_W-1:0] OFS_HI2 = ADDR_W'(11'h402);

  always_comb begin
    sel = SEL_NONE;
    if (addr == OFS_LO1)      sel = SEL_STAT;
    else if (addr == OFS_LO2) sel = SEL_CTRL;
    else if (addr == OFS_HI2) sel = SEL_XCTL;
    else if (addr == OFS_LO0) begin
      unique case (mode)
        MODE_STD, MODE_BIDIR: sel = SEL_LATCH;
        MODE_EXT:             sel = SEL_CMDQ;
        default:              sel = SEL_NONE;
      endcase
    end else if (addr == OFS_HI0) begin
      unique case (mode)
        MODE_PFIFO, MODE_EXT: sel = SEL_DATQ;
        MODE_TEST:            sel = SEL_TSTQ;
        MODE_CFG:             sel = SEL_CFGA;
        default:              sel = SEL_NONE;
      endcase
    end else if (addr == OFS_HI1) begin
      if (mode == MODE_CFG) sel = SEL_CFGB;
    end
  end
endmodule

// File: rtl/ppf_queue.sv
module ppf_queue #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full,
  output logic [$clog2(DEPTH):0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IX  = AW'(DEPTH - 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wr_ix, rd_ix;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = store[rd_ix];

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ix] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ix <= '0;
      rd_ix <= '0;
      count <= '0;
    end else begin
      if (do_push) wr_ix <= (wr_ix == LAST_IX) ? '0 : wr_ix + 1'b1;
      if (do_pop)  rd_ix <= (rd_ix == LAST_IX) ? '0 : rd_ix + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ppf_host_front.sv
module ppf_host_front
  import ppf_pkg::*;
#(
  parameter int          ADDR_W   = 11,
  parameter int          DW       = 8,
  parameter int          DEPTH    = 16,
  parameter logic [7:0]  CFGA_VAL = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_aen,
  input  logic              host_nior,
  input  logic              host_niow,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  input  logic [DW-1:0]     status_in,
  output logic [DW-1:0]     ctrl_out,
  output logic [DW-1:0]     pd_out,
  input  logic [DW-1:0]     pd_in,
  output logic              pd_oe,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_tag,
  output logic [DW-1:0]     tx_data
);
  localparam int QW = DW + 1;
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [DW-1:0] IDLE_RD = '1;

  mode_e         mode_q;
  logic          ovf_q;
  logic [DW-1:0] latch_q, ctrl_q, cfgb_q;
  logic          iow_rise, ior_rise, wr_go, rd_go;
  sel_e          sel;
  logic          q_push, q_pop, q_empty, q_full, q_tag_in;
  logic [QW-1:0] q_head;
  logic [CW-1:0] q_count;
  logic          dir_rev;

  ppf_edge u_wr_edge (.clk(clk), .rst_n(rst_n), .strobe_n(host_niow), .rise(iow_rise));
  ppf_edge u_rd_edge (.clk(clk), .rst_n(rst_n), .strobe_n(host_nior), .rise(ior_rise));

  ppf_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(host_addr), .mode(mode_q), .sel(sel));

  assign wr_go   = iow_rise & ~host_aen;
  assign rd_go   = ior_rise & ~host_aen;
  assign dir_rev = ctrl_q[DIR_BIT];

  // queue entry source: command offset (forward only), data offset, test offset
  always_comb begin
    q_push   = 1'b0;
    q_tag_in = 1'b0;
    if (wr_go) begin
      unique case (sel)
        SEL_CMDQ: begin q_push = ~dir_rev; q_tag_in = 1'b1; end
        SEL_DATQ, SEL_TSTQ: q_push = 1'b1;
        default: ;
      endcase
    end
  end

  assign tx_valid = ~q_empty & (mode_q != MODE_TEST);
  assign q_pop    = (tx_valid & tx_ready) | (rd_go & (sel == SEL_TSTQ));

  ppf_queue #(.WIDTH(QW), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n),
    .push(q_push), .push_data({q_tag_in, host_wdata}),
    .pop(q_pop), .head(q_head),
    .empty(q_empty), .full(q_full), .count(q_count)
  );

  assign tx_tag  = q_head[DW];
  assign tx_data = q_head[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_STD;
      ovf_q   <= 1'b0;
      latch_q <= '0;
      ctrl_q  <= '0;
      cfgb_q  <= '0;
    end else begin
      if (q_push && q_full) ovf_q <= 1'b1;
      if (wr_go) begin
        unique case (sel)
          SEL_LATCH: latch_q <= host_wdata;
          SEL_CTRL:  ctrl_q  <= host_wdata;
          SEL_CFGB:  cfgb_q  <= host_wdata;
          SEL_XCTL: begin
            mode_q <= mode_e'(host_wdata[7:5]);
            if (host_wdata[0]) ovf_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = IDLE_RD;
    unique case (sel)
      SEL_LATCH: rd_mux = pd_in;
      SEL_STAT:  rd_mux = status_in;
      SEL_CTRL:  rd_mux = ctrl_q;
      SEL_TSTQ:  rd_mux = q_empty ? IDLE_RD : q_head[DW-1:0];
      SEL_CFGA:  rd_mux = CFGA_VAL;
      SEL_CFGB:  rd_mux = cfgb_q;
      SEL_XCTL:  rd_mux = {mode_q, 2'b00, q_full, q_empty, ovf_q};
      default:   rd_mux = IDLE_RD;
    endcase
  end

  assign host_rdata = (!host_nior && !host_aen) ? rd_mux : IDLE_RD;
  assign ctrl_out   = ctrl_q;
  assign pd_out     = latch_q;
  assign pd_oe      = ~dir_rev;
endmodule

// File: rtl/ppf_host_front_chk.sv
module ppf_host_front_chk
  import ppf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_aen,
  input logic          host_niow,
  input logic [7:0]    host_rdata,
  input logic [7:0]    pd_out,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          tx_tag,
  input logic [7:0]    tx_data,
  input logic [CW-1:0] q_count,
  input mode_e         mode_q
);
  AST_AEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    host_aen |-> host_rdata == 8'hFF); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(DEPTH)); // R7

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (!tx_valid || ($stable(tx_tag) && $stable(tx_data)))); // R8

  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == '0) |-> !tx_valid); // R8

  AST_TEST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_TEST) |-> !tx_valid); // R9

  AST_LATCH_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(host_niow, 2) |-> $stable(pd_out)); // R2
endmodule

bind ppf_host_front ppf_host_front_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_aen(host_aen), .host_niow(host_niow),
  .host_rdata(host_rdata), .pd_out(pd_out), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_tag(tx_tag), .tx_data(tx_data),
  .q_count(q_count), .mode_q(mode_q)
);

// File: tb/ppf_host_front_tb.sv
module ppf_host_front_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] STAT_VAL = 8'h5A;
  localparam logic [7:0] PIN_EXT  = 8'hC3;
  localparam int NVEC = 25;

  // {op(1: 1=read-check), addr(11), data(8), expect(8)}
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b0, 11'h402, 8'h00, 8'h00},
    {1'b0, 11'h000, 8'hA5, 8'h00},
    {1'b1, 11'h000, 8'h00, 8'hA5},  // R2
    {1'b0, 11'h002, 8'h0F, 8'h00},
    {1'b1, 11'h002, 8'h00, 8'h0F},  // R11
    {1'b1, 11'h001, 8'h00, 8'h5A},  // R11
    {1'b0, 11'h003, 8'h77, 8'h00},
    {1'b1, 11'h003, 8'h00, 8'hFF},  // R12
    {1'b0, 11'h402, 8'hA0, 8'h00},
    {1'b1, 11'h000, 8'h00, 8'hFF},  // R12
    {1'b1, 11'h400, 8'h00, 8'hFF},
    {1'b1, 11'h002, 8'h00, 8'h0F},
    {1'b1, 11'h402, 8'h00, 8'hA2},
    {1'b0, 11'h402, 8'hE0, 8'h00},
    {1'b1, 11'h400, 8'h00, 8'h14},  // R10
    {1'b0, 11'h400, 8'h33, 8'h00},
    {1'b1, 11'h400, 8'h00, 8'h14},
    {1'b0, 11'h401, 8'h6C, 8'h00},
    {1'b1, 11'h401, 8'h00, 8'h6C},
    {1'b0, 11'h402, 8'h20, 8'h00},
    {1'b0, 11'h000, 8'h3C, 8'h00},
    {1'b1, 11'h000, 8'h00, 8'h3C},
    {1'b0, 11'h002, 8'h00, 8'h00},
    {1'b0, 11'h402, 8'h00, 8'h00},
    {1'b1, 11'h402, 8'h00, 8'h02}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] host_addr = '0;
  logic        host_aen = 1'b0;
  logic        host_nior = 1'b1;
  logic        host_niow = 1'b1;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata, ctrl_out, pd_out, pd_in, tx_data;
  logic        pd_oe, tx_valid, tx_tag;
  logic        tx_ready = 1'b0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  assign pd_in = pd_oe ? pd_out : PIN_EXT;

  ppf_host_front u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_aen(host_aen),
    .host_nior(host_nior), .host_niow(host_niow), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .status_in(STAT_VAL), .ctrl_out(ctrl_out),
    .pd_out(pd_out), .pd_in(pd_in), .pd_oe(pd_oe), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_tag(tx_tag), .tx_data(tx_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [10:0] a, input logic [7:0] d, input logic aen = 1'b0);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_aen = aen; host_niow = 1'b0;
    @(negedge clk);
    host_niow = 1'b1;
    @(negedge clk);
    host_aen = 1'b0;
  endtask

  task automatic host_rd(input logic [10:0] a, output logic [7:0] d, input logic aen = 1'b0);
    @(negedge clk);
    host_addr = a; host_aen = aen; host_nior = 1'b0;
    @(negedge clk);
    d = host_rdata;
    host_nior = 1'b1;
    @(negedge clk);
    host_aen = 1'b0;
  endtask

  task automatic take_one();
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pd_out", {1'b0, pd_out}, 9'h000);
    check("R1 tx_valid", {8'h00, tx_valid}, 9'h000);
    check("R1 pd_oe", {8'h00, pd_oe}, 9'h001);
    host_rd(11'h402, rd);
    check("R1 ecr", {1'b0, rd}, 9'h002);
    host_rd(11'h002, rd);
    check("R1 ctrl", {1'b0, rd}, 9'h000);

    // table walk: R2 R10 R11 R12
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][27]) begin
        host_rd(VEC[i][26:16], rd);
        check($sformatf("table vec %0d (R2 R10 R11 R12)", i), {1'b0, rd}, {1'b0, VEC[i][7:0]});
      end else begin
        host_wr(VEC[i][26:16], VEC[i][15:8]);
      end
    end
    check("R11 ctrl_out", {1'b0, ctrl_out}, 9'h000);

    // R4 tagging and order in mode 011
    host_wr(11'h402, 8'h60);
    host_wr(11'h000, 8'h11);
    host_wr(11'h400, 8'h22);
    host_wr(11'h000, 8'h33);
    check("R4 head 1", {tx_valid, tx_tag, 7'h00}, 9'h180);
    check("R4 data 1", {1'b0, tx_data}, 9'h011);
    repeat (3) @(negedge clk);
    check("R8 hold", {tx_tag, tx_data}, 9'h111);
    take_one();
    check("R4 head 2", {tx_tag, tx_data}, 9'h022);
    take_one();
    check("R4 head 3", {tx_tag, tx_data}, 9'h133);
    take_one();
    check("R8 empty", {8'h00, tx_valid}, 9'h000);

    // R5 reverse direction drops command writes
    host_wr(11'h002, 8'h20);
    check("R2 pd_oe reverse", {8'h00, pd_oe}, 9'h000);
    host_wr(11'h000, 8'h77);
    check("R5 dropped", {8'h00, tx_valid}, 9'h000);
    host_wr(11'h002, 8'h00);

    // R6 / R7 fill in mode 010
    host_wr(11'h402, 8'h40);
    for (int k = 0; k < 17; k++) host_wr(11'h400, 8'(k));
    host_rd(11'h402, rd);
    check("R7 full+ovf", {1'b0, rd}, 9'h045);
    for (int k = 0; k < 16; k++) begin
      check($sformatf("R6 entry %0d", k), {tx_valid, tx_tag, tx_data[6:0]}, {2'b10, 7'(k)});
      take_one();
    end
    check("R7 extra dropped", {8'h00, tx_valid}, 9'h000);
    host_rd(11'h402, rd);
    check("R7 ovf sticky", {1'b0, rd}, 9'h043);
    host_wr(11'h402, 8'h41);
    host_rd(11'h402, rd);
    check("R7 ovf cleared", {1'b0, rd}, 9'h042);

    // R9 test mode loopback
    host_wr(11'h402, 8'hC0);
    host_wr(11'h400, 8'h9E);
    host_wr(11'h400, 8'h4B);
    check("R9 no tx", {8'h00, tx_valid}, 9'h000);
    host_rd(11'h400, rd);
    check("R9 read 1", {1'b0, rd}, 9'h09E);
    host_rd(11'h400, rd);
    check("R9 read 2", {1'b0, rd}, 9'h04B);
    host_rd(11'h402, rd);
    check("R9 drained", {1'b0, rd}, 9'h0C2);

    // R3 AEN blocks access
    host_wr(11'h402, 8'h00, 1'b1);
    host_wr(11'h002, 8'hFF, 1'b1);
    host_rd(11'h402, rd, 1'b1);
    check("R3 read blocked", {1'b0, rd}, 9'h0FF);
    host_rd(11'h402, rd);
    check("R3 ecr kept", {1'b0, rd}, 9'h0C2);
    host_rd(11'h002, rd);
    check("R3 ctrl kept", {1'b0, rd}, 9'h000);

    // R1 reset mid-run
    host_wr(11'h402, 8'h00);
    host_wr(11'h000, 8'h99);
    host_wr(11'h002, 8'h2C);
    check("R2 latch", {1'b0, pd_out}, 9'h099);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 pd_out again", {1'b0, pd_out}, 9'h000);
    check("R1 ctrl_out again", {1'b0, ctrl_out}, 9'h000);
    host_rd(11'h402, rd);
    check("R1 ecr again", {1'b0, rd}, 9'h002);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule